// File: doc/BRIEF.md
# Open-Row DRAM Access Controller

This controller sits between a processor-side request port and a DRAM device whose row and column addresses share one bus. Each request names a (row, column) cell and either writes one data word or reads one back. The controller keeps the most recently activated row open. A later request to that same row needs only a column strobe. A request to any other row first drops the row strobe to close the open row, then activates the new row, then strobes the column.

The controller also keeps the stored charge fresh. A free-running interval counter raises a refresh request. In response, the controller activates one row without any column strobe, which acts as a dummy read, and then closes it again. A row pointer steps through all rows in turn. A refresh is never inserted into a column cycle that is already running. Once that cycle finishes, the refresh takes precedence over waiting requests. Cycle counts for precharge, row-to-column delay and column pulse width are parameters, and each is at least one cycle.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, `dram_ras`, `dram_cas` and `rsp_valid` are low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low whenever `dram_cas` is high. Every accepted request produces exactly one column strobe, and requests are served in order.
- R3: A request to the row that is currently open raises `dram_cas` only, with no new row activation. Four consecutive reads of one row, starting with the row closed, give one rising edge of `dram_ras` and four rising edges of `dram_cas`.
- R4: A request to a row other than the open one first drops `dram_ras`, holds it low for at least T_RP cycles, and then raises it again.
- R5: `dram_addr` carries the row number in the cycle where `dram_ras` rises. It carries the column number, zero-extended, on every cycle that `dram_cas` is high, and it stays stable for the whole column pulse.
- R6: `dram_cas` rises no earlier than T_RCD cycles after `dram_ras` rises, and every column pulse lasts exactly T_CAS cycles.
- R7: For a read, `rsp_valid` is high for exactly one cycle, the cycle right after the column pulse ends. `rsp_rdata` then holds the word that was sampled from `dram_dq_in` on the last cycle of the pulse, which is the most recent value written to that cell.
- R8: For a write, `dram_we` is high and `dram_dq_out` holds the request data for the whole column pulse. A write produces no `rsp_valid`.
- R9: A refresh is requested every REF_PERIOD cycles. It is performed as a row activation with no column strobe, lasting T_RCD+T_CAS cycles, and the row is closed at the end.
- R10: Refreshes visit rows 0, 1, …, NUM_ROWS-1 in that order and then wrap back to row 0.
- R11: A pending refresh waits until the current column cycle has finished, then wins over pending requests. Under a continuous request stream, consecutive refreshes are still between REF_PERIOD-16 and REF_PERIOD+16 cycles apart.
- R12: `dram_cas` is never high while `dram_ras` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row of the cell |
| req_col | input | COL_W | Column of the cell |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle pulse: read data is present |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras | output | 1 | Row strobe, active high; held high while a row is open |
| dram_cas | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Write enable during the column strobe |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to the device |
| dram_dq_in | input | DATA_W | Read data from the device, valid during the column strobe |

## Verification
The assertions take two things for granted. First, `dram_dq_in` is settled by the last cycle of each column pulse. Second, request fields stay put only while the request is being offered, and nothing later depends on them. The bench meets the first condition with a device model that drives read data combinationally from the latched row and the column on the bus. It meets the second by changing request fields only on falling edges and dropping `req_valid` right after the accepting edge. It compares every pin transition against an in-order queue of accepted requests and a shadow copy of memory. Traffic includes a same-row burst started just after a refresh, a hit write followed by a read-back, a row miss, and a saturating stream across all rows so that refresh has to win against steady demand.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_CAS,
        S_RACT,
        S_RPRE
    } seq_st_e;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
    } pin_cmd_t;

    // Counter load value for a phase of n cycles (n is at least one).
    function automatic int unsigned phase_load(int unsigned n);
        return (n < 1) ? 0 : n - 1;
    endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int REF_PERIOD = 200,
    parameter int NUM_ROWS   = 4,
    parameter int ROW_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic             done,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int REF_W = $clog2(REF_PERIOD + 1);

    logic [REF_W-1:0] tick;
    logic             wrap;

    assign wrap = (tick == REF_W'(REF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
            if (done)
                row <= (row == ROW_W'(NUM_ROWS - 1)) ? '0 : row + 1'b1;
        end
    end

    assert_row_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (done && row == ROW_W'(NUM_ROWS - 1)) |=> (row == '0));

endmodule

// File: rtl/fpm_page_tracker.sv
module fpm_page_tracker #(
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             open_vld,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (clr) begin
            open_vld <= 1'b0;
        end else if (set) begin
            open_vld <= 1'b1;
            open_row <= set_row;
        end
    end

    assign hit = open_vld && (req_row == open_row);

    assert_set_clr_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(set && clr));

endmodule

// File: rtl/fpm_cmd_seq.sv
module fpm_cmd_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hit,
    input  logic              ref_pend,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    output logic              ref_done,
    output logic              trk_set,
    output logic              trk_clr,
    output logic [ROW_W-1:0]  trk_row,
    output pin_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int CNT_W   = $clog2(T_RP + T_RCD + T_CAS + 1);
    localparam int L_RP    = phase_load(T_RP);
    localparam int L_RCD   = phase_load(T_RCD);
    localparam int L_CAS   = phase_load(T_CAS);
    localparam int L_REFON = phase_load(T_RCD + T_CAS);

    typedef struct packed {
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
    } acc_t;

    seq_st_e    st;
    logic [CNT_W-1:0] cnt;
    logic       ras_q;
    logic       for_ref;
    acc_t       cur;
    logic       take;
    logic       last;

    assign req_ready = (st == S_IDLE) && !ref_pend;
    assign take      = req_ready && req_valid;
    assign last      = (cnt == '0);

    // Tracker control: open on activation for an access, close on precharge.
    assign trk_row  = (st == S_IDLE) ? req_row : cur.row;
    assign trk_set  = (take && !hit && !ras_q) || (st == S_PRE && last && !for_ref);
    assign trk_clr  = (st == S_IDLE) && ras_q && ((ref_pend) || (take && !hit));
    assign ref_ack  = ((st == S_IDLE) && ref_pend && !ras_q) || (st == S_PRE && last && for_ref);
    assign ref_done = (st == S_RACT) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cnt       <= '0;
            ras_q     <= 1'b0;
            for_ref   <= 1'b0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (ref_pend) begin
                        if (ras_q) begin
                            st      <= S_PRE;
                            ras_q   <= 1'b0;
                            for_ref <= 1'b1;
                            cnt     <= CNT_W'(L_RP);
                        end else begin
                            st    <= S_RACT;
                            ras_q <= 1'b1;
                            cnt   <= CNT_W'(L_REFON);
                        end
                    end else if (req_valid) begin
                        cur <= '{we: req_write, row: req_row, col: req_col, data: req_wdata};
                        if (hit) begin
                            st  <= S_CAS;
                            cnt <= CNT_W'(L_CAS);
                        end else if (ras_q) begin
                            st      <= S_PRE;
                            ras_q   <= 1'b0;
                            for_ref <= 1'b0;
                            cnt     <= CNT_W'(L_RP);
                        end else begin
                            st    <= S_ACT;
                            ras_q <= 1'b1;
                            cnt   <= CNT_W'(L_RCD);
                        end
                    end
                end
                S_PRE: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else if (for_ref) begin
                        st    <= S_RACT;
                        ras_q <= 1'b1;
                        cnt   <= CNT_W'(L_REFON);
                    end else begin
                        st    <= S_ACT;
                        ras_q <= 1'b1;
                        cnt   <= CNT_W'(L_RCD);
                    end
                end
                S_ACT: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        st  <= S_CAS;
                        cnt <= CNT_W'(L_CAS);
                    end
                end
                S_CAS: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        st <= S_IDLE;
                        if (!cur.we) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= dq_in;
                        end
                    end
                end
                S_RACT: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        st    <= S_RPRE;
                        ras_q <= 1'b0;
                        cnt   <= CNT_W'(L_RP);
                    end
                end
                S_RPRE: begin
                    if (!last)
                        cnt <= cnt - 1'b1;
                    else
                        st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.ras = ras_q;
        cmd.cas = (st == S_CAS);
        cmd.we  = (st == S_CAS) && cur.we;
        dq_out  = cur.data;
        if (st == S_CAS)
            addr = ADDR_W'(cur.col);
        else if (st == S_RACT)
            addr = ADDR_W'(ref_row);
        else
            addr = ADDR_W'(cur.row);
    end

    assert_cas_needs_ras_R12: assert property (@(posedge clk) disable iff (rst)
        (st == S_CAS) |-> ras_q);

    assert_hit_keeps_row_R3: assert property (@(posedge clk) disable iff (rst)
        (st == S_CAS && $past(st) == S_IDLE) |-> $past(ras_q));

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 2,
    parameter int COL_W      = 2,
    parameter int DATA_W     = 8,
    parameter int NUM_ROWS   = 1 << ROW_W,
    parameter int T_RP       = 2,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int REF_PERIOD = 200,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_we,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    input  logic [DATA_W-1:0] dram_dq_in
);
    logic             ref_pend, ref_ack, ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             trk_set, trk_clr, open_vld, hit;
    logic [ROW_W-1:0] trk_row;
    pin_cmd_t         cmd;

    fpm_refresh_timer #(
        .REF_PERIOD(REF_PERIOD), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)
    ) u_ref (
        .clk(clk), .rst(rst), .ack(ref_ack), .done(ref_done),
        .pend(ref_pend), .row(ref_row)
    );

    fpm_page_tracker #(.ROW_W(ROW_W)) u_page (
        .clk(clk), .rst(rst), .set(trk_set), .clr(trk_clr),
        .set_row(trk_row), .req_row(req_row),
        .open_vld(open_vld), .hit(hit)
    );

    fpm_cmd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .hit(hit), .ref_pend(ref_pend), .ref_row(ref_row),
        .ref_ack(ref_ack), .ref_done(ref_done),
        .trk_set(trk_set), .trk_clr(trk_clr), .trk_row(trk_row),
        .cmd(cmd), .addr(dram_addr), .dq_out(dram_dq_out), .dq_in(dram_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign dram_ras = cmd.ras;
    assign dram_cas = cmd.cas;
    assign dram_we  = cmd.we;

    assert_ready_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !dram_cas);

    assert_col_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (dram_cas && $past(dram_cas)) |-> $stable(dram_addr));

    assert_hit_matches_open_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (open_vld && dram_ras));

endmodule

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
    localparam int ROW_W = 2, COL_W = 2, DATA_W = 8;
    localparam int ROWS = 4, COLS = 4;
    localparam int T_RP = 2, T_RCD = 2, T_CAS = 2;
    localparam int REF_PERIOD = 300;
    localparam int ADDR_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, dram_ras, dram_cas, dram_we;
    logic [DATA_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
    logic [ADDR_W-1:0] dram_addr;

    always #5 clk = ~clk;

    fpm_dram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .NUM_ROWS(ROWS),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .REF_PERIOD(REF_PERIOD)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
    );

    int n_cmp = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Device model and shadow memory.
    int bank [ROWS][COLS];
    int shadow [ROWS][COLS];
    int dev_row = 0;
    assign dram_dq_in = DATA_W'(bank[dev_row][int'(dram_addr) % COLS]);

    typedef struct { bit we; int row; int col; int data; } acc_s;
    acc_s acc_q[$];
    int exp_q[$];

    // Monitor state
    bit prev_ras = 0, prev_cas = 0, prev_rsp = 0, first_rise = 1, cas_seen = 0, cas_we = 0;
    int low_len = 0, since_rise = 0, cas_len = 0, prev_addr = 0;
    int ras_rises = 0, cas_rises = 0, ref_count = 0, ref_exp = 0;
    int cyc = 0, last_ref = -1, accepted = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 0; prev_cas = 0; prev_rsp = 0; cyc = 0;
        end else begin
            cyc++;
            if (dram_ras && !prev_ras) begin
                if (!first_rise) chk(low_len >= T_RP, "R4 precharge length", low_len, T_RP);
                first_rise = 0;
                dev_row = int'(dram_addr);
                ras_rises++; since_rise = 0; cas_seen = 0;
            end
            if (dram_ras) since_rise++;
            chk(!(dram_cas && !dram_ras), "R12 cas without ras", dram_cas, 0);
            if (dram_cas) chk(!req_ready, "R2 ready during cas", req_ready, 0);
            if (dram_cas && !prev_cas) begin
                chk(since_rise > T_RCD, "R6 ras-to-cas", since_rise - 1, T_RCD);
                cas_seen = 1; cas_len = 0; cas_rises++; cas_we = dram_we;
                if (acc_q.size() == 0) begin
                    chk(0, "R2 cas without request", 1, 0);
                end else begin
                    acc_s a;
                    a = acc_q.pop_front();
                    chk(dev_row == a.row, "R5 row address", dev_row, a.row);
                    chk(int'(dram_addr) == a.col, "R5 column address", int'(dram_addr), a.col);
                    chk(dram_we == a.we, "R8 write enable", dram_we, a.we);
                    if (a.we) begin
                        chk(int'(dram_dq_out) == a.data, "R8 write data", int'(dram_dq_out), a.data);
                        bank[dev_row][int'(dram_addr) % COLS] = int'(dram_dq_out);
                    end
                end
            end
            if (dram_cas) begin
                cas_len++;
                if (prev_cas) begin
                    if (int'(dram_addr) != prev_addr) chk(0, "R5 address stable", int'(dram_addr), prev_addr);
                    if (dram_we != cas_we) chk(0, "R8 we stable", dram_we, cas_we);
                end
            end
            if (!dram_cas && prev_cas) chk(cas_len == T_CAS, "R6 cas width", cas_len, T_CAS);
            if (!dram_ras && prev_ras) begin
                if (!cas_seen) begin
                    chk(dev_row == ref_exp, "R10 refresh row order", dev_row, ref_exp);
                    chk(since_rise == T_RCD + T_CAS, "R9 refresh activation length", since_rise, T_RCD + T_CAS);
                    if (last_ref < 0)
                        chk(cyc <= REF_PERIOD + 16, "R9 first refresh time", cyc, REF_PERIOD);
                    else
                        chk((cyc - last_ref) <= REF_PERIOD + 16 && (cyc - last_ref) >= REF_PERIOD - 16,
                            "R11 refresh interval", cyc - last_ref, REF_PERIOD);
                    last_ref = cyc;
                    ref_exp = (ref_exp + 1) % ROWS;
                    ref_count++;
                end
                low_len = 0;
            end
            if (!dram_ras) low_len++;
            if (rsp_valid) begin
                chk(!prev_rsp, "R7 single-cycle response", 1, 0);
                if (exp_q.size() == 0) chk(0, "R7 unexpected response", 1, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(rsp_rdata) == e, "R7 read data", int'(rsp_rdata), e);
                end
            end
            prev_ras = dram_ras; prev_cas = dram_cas; prev_rsp = rsp_valid;
            prev_addr = int'(dram_addr);
        end
    end

    task automatic do_req(input bit wr, input int row, input int col, input int data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = DATA_W'(data);
        while (!req_ready) @(negedge clk);
        acc_q.push_back('{we: wr, row: row, col: col, data: data});
        accepted++;
        if (wr) shadow[row][col] = data;
        else exp_q.push_back(shadow[row][col]);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        while (acc_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = ref_count;
        while (ref_count == r0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int r0, c0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                bank[r][c] = (r * 16 + c + 'h31) % 256;
                shadow[r][c] = bank[r][c];
            end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!dram_ras && !dram_cas && !rsp_valid, "R1 reset outputs idle", {dram_ras, dram_cas, rsp_valid}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        // Same-row burst right after a refresh (row closed).
        wait_refresh();
        r0 = ras_rises; c0 = cas_rises;
        for (int c = 0; c < 4; c++) do_req(0, 1, c, 0);
        drain();
        chk(ras_rises - r0 == 1, "R3 one activation for burst", ras_rises - r0, 1);
        chk(cas_rises - c0 == 4, "R3 four column strobes", cas_rises - c0, 4);

        // Hit write then read back.
        r0 = ras_rises;
        do_req(1, 1, 2, 'h5A);
        do_req(0, 1, 2, 0);
        drain();
        chk(ras_rises == r0, "R3 hit write/read no activation", ras_rises - r0, 0);

        // Row miss.
        r0 = ras_rises;
        do_req(0, 2, 1, 0);
        drain();
        chk(ras_rises - r0 == 1, "R4 miss re-activates", ras_rises - r0, 1);

        // Saturating stream over all rows, mixed reads and writes.
        for (int i = 0; i < 400; i++) begin
            int row, col;
            row = (i * 3 + i / 5) % ROWS;
            col = (i * 7) % COLS;
            do_req((i % 3) == 0, row, col, (i * 37 + 11) % 256);
        end
        drain();

        repeat (3 * REF_PERIOD) @(negedge clk);
        chk(ref_count >= ROWS + 2, "R10 refresh wrapped past last row", ref_count, ROWS + 2);
        chk(cas_rises == accepted, "R2 one strobe per request", cas_rises, accepted);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule